// File: doc/BRIEF.md
# Master Video Sync Timing Generator

This block produces the horizontal, field and composite sync timing for interlaced standard-definition video. It runs from a sample clock at twice the luma rate. It covers both the 525-line/60 Hz and the 625-line/50 Hz line standards. A horizontal position counter and a 1-based line counter are kept internally and are also driven out. From those counters the block decodes four things: the sync pulses, a combined horizontal/vertical blanking flag, the field indicator, and the composite sync.

The surrounding video pipeline sets the line standard, one polarity bit for each sync output, and a 3-bit code. That code delays the horizontal sync pulse by a whole number of sample clocks. The standard is taken up only at a frame boundary, and the phase code only at a line boundary, so neither setting can produce a shortened line, frame or pulse. Polarity bits act at once.

Top module: `vid_sync_master`

## Requirements
- R1: `hpos_o` counts from 0 to H_TOTAL-1 and then wraps to 0. H_TOTAL is H_TOTAL_525 (default 1716) while the 525 standard is in force (std_sel = 0) and H_TOTAL_625 (default 1728) for 625 (std_sel = 1). `line_o` advances by one at each wrap, runs from 1 to 525 or 1 to 625, and then returns to 1.
- R2: `blank_o` is high for the whole line on the vertical blanking lines. For 525 these are lines 1 to 19 and 264 to 282. For 625 they are lines 1 to 22, 311 to 335, and 624 to 625.
- R3: With sync activity defined as high, horizontal sync is active for exactly HSYNC_W clocks (default 128). The pulse covers `hpos_o` values from P to P+HSYNC_W-1, where P is the phase code in force.
- R4: The phase code is sampled only on the last clock of a line (and during reset). A change made in mid-line leaves the current line's pulse where it was. The new delay applies from the next line onward.
- R5: On lines outside vertical blanking, `blank_o` is low exactly for `hpos_o` values from ACT_START to ACT_START+ACT_W-1 (defaults 244 and 1440). It is high everywhere else.
- R6: `field_o` is 0 from line 1 up to the line before the second field starts. It is 1 from that line to the end of the frame. The second field starts at line 264 for 525 and at line 313 for 625. `fvsync_o` carries the same field signal through its polarity bit.
- R7: Each sync output has its own polarity bit. A value of 1 drives activity as high and 0 drives it as low. A polarity change shows on the output in the same cycle.
- R8: On the first three lines of each field (525: lines 1 to 3 and 264 to 266; 625: lines 1 to 3 and 313 to 315), composite sync is active while `hpos_o` is below H_TOTAL-HSYNC_W. On all other lines composite sync equals the horizontal sync pulse.
- R9: Reset gives `hpos_o` = 0 and `line_o` = 1, and loads the standard and the phase code from their inputs. After reset, `std_sel` is sampled only on the last clock of the final line of a frame. A change at any other time leaves the line length and the line count as they were until that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, twice the luma rate |
| rst_n | input | 1 | Synchronous active-low reset |
| std_sel | input | 1 | Line standard: 0 = 525/60, 1 = 625/50 |
| hsync_pol | input | 1 | Horizontal sync polarity, 1 = active high |
| fvsync_pol | input | 1 | Field sync polarity, 1 = active high |
| csync_pol | input | 1 | Composite sync polarity, 1 = active high |
| hphase | input | PHASE_W (3) | Horizontal sync delay in sample clocks |
| hsync_o | output | 1 | Horizontal sync |
| fvsync_o | output | 1 | Field sync (field indicator with polarity) |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Horizontal or vertical blanking |
| field_o | output | 1 | 0 in first field, 1 in second field |
| line_o | output | 10 | Current line number, 1-based |
| hpos_o | output | HCNT_W (11) | Horizontal position in sample clocks |

## Verification
The bench builds the generator with short lines: 60 clocks for 525 and 64 for 625, an 8-clock sync pulse, and active video from 16 to 47. The vertical line ranges keep their full values. One full frame of each standard therefore fits in about 72,000 clocks. This puts several things within reach: every blanking edge, both field transitions, the composite sync lines, frame wraps in both standards, and a standard change taking effect at the frame boundary. The shortened pulse and active windows still leave room between the largest phase delay and the start of active video.

// File: rtl/vsg_pkg.sv
// Shared definitions for the master video sync generator.
// Assumes line numbers are 1-based and fit in LINE_W bits.
package vsg_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } line_std_e;

    localparam int LINE_W       = 10;
    localparam int LINES_525    = 525;
    localparam int LINES_625    = 625;
    localparam int F2_START_525 = 264;
    localparam int F2_START_625 = 313;
    localparam int VSYNC_LINES  = 3;

    // Number of lines in one frame of the given standard.
    function automatic logic [LINE_W-1:0] frame_lines(line_std_e s);
        return (s == STD_625) ? LINE_W'(LINES_625) : LINE_W'(LINES_525);
    endfunction

    // First line of the second field.
    function automatic int field2_start(line_std_e s);
        return (s == STD_625) ? F2_START_625 : F2_START_525;
    endfunction

    // True from the second-field start line to the end of the frame.
    function automatic logic second_field(line_std_e s, logic [LINE_W-1:0] ln);
        return int'(ln) >= field2_start(s);
    endfunction

    // True on a vertical blanking line.
    function automatic logic in_vblank(line_std_e s, logic [LINE_W-1:0] ln);
        int n;
        n = int'(ln);
        if (s == STD_625)
            return (n <= 22) || (n >= 311 && n <= 335) || (n >= 624);
        else
            return (n <= 19) || (n >= 264 && n <= 282);
    endfunction

    // True on the broad-pulse lines at the head of each field.
    function automatic logic in_vsync(line_std_e s, logic [LINE_W-1:0] ln);
        int n;
        int f2;
        n  = int'(ln);
        f2 = field2_start(s);
        return (n >= 1 && n <= VSYNC_LINES) || (n >= f2 && n < f2 + VSYNC_LINES);
    endfunction

endpackage

// File: rtl/vsg_hcount.sv
// Horizontal timing: position counter, latched phase code, and window decodes
// for the sync pulse, the broad pulse and active video.
// Assumes ACT_START+ACT_W and 2**PHASE_W-1+HSYNC_W both fit within a line.
module vsg_hcount
    import vsg_pkg::*;
#(
    parameter int H_TOTAL_525 = 1716,
    parameter int H_TOTAL_625 = 1728,
    parameter int HSYNC_W     = 128,
    parameter int ACT_START   = 244,
    parameter int ACT_W       = 1440,
    parameter int PHASE_W     = 3,
    localparam int H_MAX      = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525,
    localparam int HCNT_W     = $clog2(H_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_std_e         std,
    input  logic [PHASE_W-1:0] phase_sel,
    output logic [HCNT_W-1:0] hcnt,
    output logic              line_end,
    output logic              hsync_act,
    output logic              broad_act,
    output logic              hactive
);

    localparam logic [HCNT_W-1:0] LAST_525  = HCNT_W'(H_TOTAL_525 - 1);
    localparam logic [HCNT_W-1:0] LAST_625  = HCNT_W'(H_TOTAL_625 - 1);
    localparam logic [HCNT_W-1:0] PULSE_LEN = HCNT_W'(HSYNC_W);
    localparam logic [HCNT_W-1:0] ACT_LO    = HCNT_W'(ACT_START);
    localparam logic [HCNT_W-1:0] ACT_HI    = HCNT_W'(ACT_START + ACT_W);

    logic [HCNT_W-1:0]  last_pos;
    logic [HCNT_W-1:0]  broad_end;
    logic [HCNT_W-1:0]  pulse_lo;
    logic [PHASE_W-1:0] phase_q;

    // Last position of the line for the standard in force.
    always_comb begin
        last_pos  = (std == STD_625) ? LAST_625 : LAST_525;
        broad_end = last_pos - HCNT_W'(HSYNC_W - 1);
        line_end  = (hcnt == last_pos);
    end

    // Position counter, wraps on the last clock of a line.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + 1'b1;
    end

    // Phase code taken only at a line boundary so no pulse is cut short.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= phase_sel;
        else if (line_end) phase_q <= phase_sel;
    end

    // Window decodes against the running position.
    always_comb begin
        pulse_lo  = HCNT_W'(phase_q);
        hsync_act = (hcnt >= pulse_lo) && (hcnt < pulse_lo + PULSE_LEN);
        broad_act = (hcnt < broad_end);
        hactive   = (hcnt >= ACT_LO) && (hcnt < ACT_HI);
    end

    a_r1_hpos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= last_pos);

    a_r1_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hcnt == '0));

    a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(phase_q));

endmodule

// File: rtl/vsg_vcount.sv
// Vertical timing: 1-based line counter, standard latch at frame end, and
// line-range decodes for field, vertical blanking and broad-pulse lines.
// Assumes line_end pulses for one clock on the last sample of every line.
module vsg_vcount
    import vsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              std_sel,
    output line_std_e         std_q,
    output logic [LINE_W-1:0] line,
    output logic              field,
    output logic              vblank,
    output logic              vsync_line
);

    logic frame_end;

    // Frame ends on the last clock of the final line.
    always_comb frame_end = line_end && (line == frame_lines(std_q));

    // Line counter, 1-based.
    always_ff @(posedge clk) begin
        if (!rst_n)         line <= LINE_W'(1);
        else if (frame_end) line <= LINE_W'(1);
        else if (line_end)  line <= line + 1'b1;
    end

    // Standard select is taken only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         std_q <= line_std_e'(std_sel);
        else if (frame_end) std_q <= line_std_e'(std_sel);
    end

    // Per-line decodes.
    always_comb begin
        field      = second_field(std_q, line);
        vblank     = in_vblank(std_q, line);
        vsync_line = in_vsync(std_q, line);
    end

    a_r1_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        (line >= LINE_W'(1)) && (line <= frame_lines(std_q)));

    a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (line == LINE_W'(1)));

    a_r9_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(std_q));

endmodule

// File: rtl/vsg_polarity.sv
// Applies a per-output polarity bit to a vector of active-high sync flags.
// Assumes pol = 1 means active high; purely combinational.
module vsg_polarity #(
    parameter int N = 3
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] pol,
    output logic [N-1:0] sync
);

    for (genvar gi = 0; gi < N; gi++) begin : g_pol
        // Pass through or invert one output.
        assign sync[gi] = pol[gi] ? act[gi] : ~act[gi];
    end

endmodule

// File: rtl/vid_sync_master.sv
// Master sync generator for 525/60 and 625/50 interlaced video.
// Drives horizontal, field and composite sync, blanking, field and counters.
// Assumes a sample clock at twice the luma rate; outputs are decoded from
// registered counters and the polarity inputs.
module vid_sync_master
    import vsg_pkg::*;
#(
    parameter int H_TOTAL_525 = 1716,
    parameter int H_TOTAL_625 = 1728,
    parameter int HSYNC_W     = 128,
    parameter int ACT_START   = 244,
    parameter int ACT_W       = 1440,
    parameter int PHASE_W     = 3,
    localparam int H_MAX      = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525,
    localparam int HCNT_W     = $clog2(H_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               std_sel,
    input  logic               hsync_pol,
    input  logic               fvsync_pol,
    input  logic               csync_pol,
    input  logic [PHASE_W-1:0] hphase,
    output logic               hsync_o,
    output logic               fvsync_o,
    output logic               csync_o,
    output logic               blank_o,
    output logic               field_o,
    output logic [LINE_W-1:0]  line_o,
    output logic [HCNT_W-1:0]  hpos_o
);

    line_std_e         std_q;
    logic [HCNT_W-1:0] hcnt;
    logic              line_end;
    logic              hsync_act;
    logic              broad_act;
    logic              hactive;
    logic [LINE_W-1:0] line;
    logic              field;
    logic              vblank;
    logic              vsync_line;
    logic              csync_act;
    logic [2:0]        sync_vec;

    vsg_hcount #(
        .H_TOTAL_525 (H_TOTAL_525),
        .H_TOTAL_625 (H_TOTAL_625),
        .HSYNC_W     (HSYNC_W),
        .ACT_START   (ACT_START),
        .ACT_W       (ACT_W),
        .PHASE_W     (PHASE_W)
    ) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .std       (std_q),
        .phase_sel (hphase),
        .hcnt      (hcnt),
        .line_end  (line_end),
        .hsync_act (hsync_act),
        .broad_act (broad_act),
        .hactive   (hactive)
    );

    vsg_vcount u_vcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .std_sel    (std_sel),
        .std_q      (std_q),
        .line       (line),
        .field      (field),
        .vblank     (vblank),
        .vsync_line (vsync_line)
    );

    // Composite sync: broad pulses on the vertical sync lines, else Hsync.
    always_comb csync_act = vsync_line ? broad_act : hsync_act;

    vsg_polarity #(.N(3)) u_pol (
        .act  ({csync_act, field, hsync_act}),
        .pol  ({csync_pol, fvsync_pol, hsync_pol}),
        .sync (sync_vec)
    );

    // Output assignment.
    always_comb begin
        hsync_o  = sync_vec[0];
        fvsync_o = sync_vec[1];
        csync_o  = sync_vec[2];
        blank_o  = vblank | ~hactive;
        field_o  = field;
        line_o   = line;
        hpos_o   = hcnt;
    end

endmodule

// File: tb/vid_sync_master_test.sv
`timescale 1ns/1ps
module vid_sync_master_test;

    localparam int HT5 = 60;
    localparam int HT6 = 64;
    localparam int HSW = 8;
    localparam int AST = 16;
    localparam int AW  = 32;
    localparam int HW  = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic std_sel = 1'b0;
    logic hpol = 1'b1, fpol = 1'b1, cpol = 1'b1;
    logic [2:0] hphase = 3'd0;
    logic hsync_o, fvsync_o, csync_o, blank_o, field_o;
    logic [9:0] line_o;
    logic [HW-1:0] hpos_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int mh, ml, mstd, mph;

    vid_sync_master #(
        .H_TOTAL_525(HT5), .H_TOTAL_625(HT6), .HSYNC_W(HSW),
        .ACT_START(AST), .ACT_W(AW), .PHASE_W(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel),
        .hsync_pol(hpol), .fvsync_pol(fpol), .csync_pol(cpol), .hphase(hphase),
        .hsync_o(hsync_o), .fvsync_o(fvsync_o), .csync_o(csync_o),
        .blank_o(blank_o), .field_o(field_o), .line_o(line_o), .hpos_o(hpos_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (line %0d hpos %0d)", tag, act, exp, ml, mh);
        end
    endtask

    function automatic int htot(int s);
        return s ? HT6 : HT5;
    endfunction

    function automatic int exp_field(int s, int l);
        return s ? int'(l >= 313) : int'(l >= 264);
    endfunction

    function automatic int exp_vbl(int s, int l);
        if (s) return int'(l <= 22 || (l >= 311 && l <= 335) || l >= 624);
        return int'(l <= 19 || (l >= 264 && l <= 282));
    endfunction

    function automatic int exp_vsl(int s, int l);
        int f2;
        f2 = s ? 313 : 264;
        return int'((l >= 1 && l <= 3) || (l >= f2 && l <= f2 + 2));
    endfunction

    // Independent timing model, stepped at each rising edge.
    task automatic upd();
        if (!rst_n) begin
            mh = 0; ml = 1; mstd = int'(std_sel); mph = int'(hphase);
        end else if (mh == htot(mstd) - 1) begin
            mh  = 0;
            mph = int'(hphase);
            if (ml == (mstd ? 625 : 525)) begin
                ml = 1; mstd = int'(std_sel);
            end else ml++;
        end else mh++;
    endtask

    task automatic check_all();
        int f, hs, cs, vb, blk;
        chk("R1 hpos", int'(hpos_o), mh);
        chk("R1 line", int'(line_o), ml);
        f = exp_field(mstd, ml);
        chk("R6 field", int'(field_o), f);
        chk("R6 fvsync", int'(fvsync_o), fpol ? f : 1 - f);
        hs = int'(mh >= mph && mh < mph + HSW);
        chk("R3 hsync", int'(hsync_o), hpol ? hs : 1 - hs);
        cs = exp_vsl(mstd, ml) ? int'(mh < htot(mstd) - HSW) : hs;
        chk("R8 csync", int'(csync_o), cpol ? cs : 1 - cs);
        vb  = exp_vbl(mstd, ml);
        blk = int'(vb != 0 || mh < AST || mh >= AST + AW);
        if (vb != 0) chk("R2 blank", int'(blank_o), blk);
        else         chk("R5 blank", int'(blank_o), blk);
    endtask

    // One clock: model step at the edge, checks and stimulus at the falling edge.
    task automatic cyc(input bit rnd);
        @(posedge clk);
        upd();
        @(negedge clk);
        check_all();
        if (rnd) begin
            if ($urandom_range(0, 49) == 0) {hpol, fpol, cpol} = 3'($urandom);
            if (mh == 0 || $urandom_range(0, 199) == 0) hphase = 3'($urandom);
            if ($urandom_range(0, 999) == 0) std_sel = 1'($urandom);
        end
    endtask

    task automatic run_to(input int h);
        while (mh != h) cyc(1'b0);
    endtask

    task automatic run_to_line(input int l);
        while (ml != l) cyc(1'b0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1A2B3C);
        repeat (3) cyc(1'b0);
        // R9: reset state
        chk("R9 reset hpos", int'(hpos_o), 0);
        chk("R9 reset line", int'(line_o), 1);
        chk("R9 reset field", int'(field_o), 0);
        rst_n = 1'b1;

        // R4: mid-line phase change waits for the next line
        run_to(30);
        hphase = 3'd5;
        run_to(0);
        run_to(4);
        chk("R4 old phase dropped", int'(hsync_o), 0);
        cyc(1'b0);
        chk("R4 new phase start", int'(hsync_o), 1);

        // R7: polarity flips at once
        run_to(6);
        {hpol, fpol, cpol} = 3'b000;
        #1;
        chk("R7 hsync low-active", int'(hsync_o), 0);
        chk("R7 fvsync low-active", int'(fvsync_o), 1);
        chk("R7 csync low-active", int'(csync_o), 0);
        {hpol, fpol, cpol} = 3'b111;

        // R9: standard change waits for frame end
        run_to_line(100);
        std_sel = 1'b1;
        run_to(HT5 - 1);
        cyc(1'b0);
        chk("R9 old length kept", int'(hpos_o), 0);
        chk("R9 line count kept", int'(line_o), 101);
        run_to_line(1);
        chk("R9 new frame line", int'(line_o), 1);
        run_to(HT6 - 1);
        chk("R9 625 length", int'(hpos_o), HT6 - 1);

        // Random mix across frames of both standards
        for (int i = 0; i < 80000; i++) cyc(1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule